// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor

This block is a purely combinational arithmetic unit that adds or subtracts two signed two's complement operands of a configurable width. The default width is 4 bits. Two separate select inputs choose the operation. With only the add select high, the second operand passes unchanged into a ripple-carry chain of full adders. With the subtract select high, the second operand is bit-inverted and the chain's carry-in is forced high, so the chain computes the first operand plus the negated second operand. With both selects low, the second operand is gated to zero and the first operand passes straight through.

The result is always truncated to the operand width. The carry out of the sign position is never folded into the result; it is brought out on its own pin. A separate overflow pin flags a signed result that falls outside the representable range. For W bits that range runs from -2^(W-1) (sign bit set, all other bits clear) to 2^(W-1)-1. Driving both selects high is not a legal request. The unit resolves it as a subtract and raises an error pin, so downstream logic always sees a defined value.

Top module: `twos_addsub_unit`

## Requirements
- R1: With `do_add`=1 and `do_sub`=0, `result` equals (`opd_a` + `opd_b`) mod 2^W, and `carry_out` is bit W of the unsigned sum `opd_a` + `opd_b`.
- R2: With `do_sub`=1, `result` equals (`opd_a` - `opd_b`) mod 2^W, and `carry_out` is bit W of the unsigned sum `opd_a` + (bitwise inverse of `opd_b`) + 1, which is 1 exactly when `opd_a` >= `opd_b` taken as unsigned numbers.
- R3: With `do_add`=0 and `do_sub`=0, `result` equals `opd_a`, and both `carry_out` and `ovf` are 0, whatever the value of `opd_b`.
- R4: With `do_add`=1 and `do_sub`=1, every output except `ctl_err` behaves exactly as in R2 and `ctl_err` is 1. For any other select combination `ctl_err` is 0.
- R5: `ovf` is 1 exactly when the mathematically exact signed result of the selected operation lies outside -2^(W-1) to 2^(W-1)-1. The operands are read as two's complement numbers with the sign in bit W-1.
- R6: A carry out of the sign bit never changes `result`. For example, with W=4, 0111 + 1001 gives `result`=0000, `carry_out`=1 and `ovf`=0.
- R7: The range limits behave as follows with W=4. 0111 + 0001 gives 1000 with `ovf`=1. 1000 - 0001 gives 0111 with `ovf`=1. 0000 - 1000 gives 1000 with `ovf`=1. 1000 + 1111 gives 0111 with `ovf`=1.
- R8: With W=4, 0100 - 0110 gives 1110 (-2), and 0110 + 1101 gives 0011 (+3) with `ovf`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | W | First operand (minuend or augend), two's complement |
| opd_b | input | W | Second operand (subtrahend or addend), two's complement |
| do_add | input | 1 | Select addition |
| do_sub | input | 1 | Select subtraction; overrides `do_add` |
| result | output | W | Sum or difference truncated to W bits |
| carry_out | output | 1 | Carry out of the sign position |
| ovf | output | 1 | Signed overflow flag |
| ctl_err | output | 1 | Both selects were high |

## Verification
The unit holds no state, so any fault in the operand gating, the carry-in or a single adder cell reaches the ports in the same cycle as the inputs that excite it. A stuck carry-in shows up as an off-by-one `result` in add or pass-through mode while subtraction still looks correct. A broken inversion path shows up as a wrong difference. A swapped carry tap shows up as `ovf` on vectors that sit exactly on the range edges. All four select combinations are applied with every operand pair at the default width, so each such fault produces a miscompare on the first vector that exercises it.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_BAD  = 2'b11
  } op_sel_e;
endpackage

// File: rtl/addsub_operand_gate.sv
module addsub_operand_gate
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] b_in,
  input  logic         sel_add,
  input  logic         sel_sub,
  output logic [W-1:0] b_gated,
  output logic         carry_in,
  output logic         bad_sel
);
  op_sel_e op;

  always_comb begin
    op = op_sel_e'({sel_sub, sel_add});
    b_gated  = '0;
    carry_in = 1'b0;
    bad_sel  = 1'b0;
    unique case (op)
      OP_PASS: begin
        b_gated  = '0;
        carry_in = 1'b0;
      end
      OP_ADD: begin
        b_gated  = b_in;
        carry_in = 1'b0;
      end
      OP_SUB: begin
        b_gated  = ~b_in;
        carry_in = 1'b1;
      end
      OP_BAD: begin
        b_gated  = ~b_in;
        carry_in = 1'b1;
        bad_sel  = 1'b1;
      end
      default: begin
        b_gated  = '0;
        carry_in = 1'b0;
      end
    endcase
  end

  // R3
  always_comb begin : pass_gate_chk
    if (!sel_add && !sel_sub)
      assert (b_gated == '0 && !carry_in) else $error("pass mode leaks operand B");
  end
endmodule

// File: rtl/addsub_full_adder.sv
module addsub_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;

  always_comb begin
    p  = x ^ y;
    s  = p ^ ci;
    co = (x & y) | (p & ci);
  end
endmodule

// File: rtl/addsub_ripple_chain.sv
module addsub_ripple_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         c_into_msb,
  output logic         c_out_msb
);
  logic [W:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_cell
    addsub_full_adder u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (c[i]),
      .s  (s[i]),
      .co (c[i+1])
    );
  end

  assign c_into_msb = c[W-1];
  assign c_out_msb  = c[W];
endmodule

// File: rtl/twos_addsub_unit.sv
module twos_addsub_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic         do_add,
  input  logic         do_sub,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf,
  output logic         ctl_err
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_gated;
  logic         cin;
  logic         c_into_msb;
  logic         c_out_msb;

  addsub_operand_gate #(.W(W)) u_gate (
    .b_in     (opd_b),
    .sel_add  (do_add),
    .sel_sub  (do_sub),
    .b_gated  (b_gated),
    .carry_in (cin),
    .bad_sel  (ctl_err)
  );

  addsub_ripple_chain #(.W(W)) u_chain (
    .x          (opd_a),
    .y          (b_gated),
    .ci         (cin),
    .s          (result),
    .c_into_msb (c_into_msb),
    .c_out_msb  (c_out_msb)
  );

  assign carry_out = c_out_msb;
  assign ovf       = c_into_msb ^ c_out_msb;

  // R1
  always_comb begin : add_sum_chk
    if (do_add && !do_sub)
      assert ({carry_out, result} == ({1'b0, opd_a} + {1'b0, opd_b}))
        else $error("add result wrong");
  end

  // R2
  always_comb begin : sub_diff_chk
    if (do_sub)
      assert (result == W'(opd_a - opd_b)) else $error("sub result wrong");
  end

  // R3
  always_comb begin : pass_through_chk
    if (!do_add && !do_sub)
      assert (result == opd_a && !carry_out && !ovf) else $error("pass mode wrong");
  end

  // R5
  always_comb begin : no_overflow_chk
    assert (ovf == ((opd_a[MSB] == b_gated[MSB]) && (result[MSB] != opd_a[MSB])))
      else $error("overflow flag disagrees with sign rule");
  end

  // R4
  always_comb begin : bad_select_chk
    if (ctl_err) assert (do_sub && do_add) else $error("error raised without both selects");
  end
endmodule

// File: tb/test_twos_addsub_unit.sv
module test_twos_addsub_unit;
  localparam int W = 4;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic clk;
  logic rst_n;
  logic [W-1:0] opd_a, opd_b;
  logic do_add, do_sub;
  logic [W-1:0] result;
  logic carry_out, ovf, ctl_err;

  int n_vec;
  int n_bad;
  bit done;

  twos_addsub_unit #(.W(W)) i_twos_addsub_unit (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .do_add    (do_add),
    .do_sub    (do_sub),
    .result    (result),
    .carry_out (carry_out),
    .ovf       (ovf),
    .ctl_err   (ctl_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int to_signed(int u);
    return (u >= HALF) ? u - SPAN : u;
  endfunction

  task automatic check(input string tag, input int a, input int b,
                       input bit ad, input bit sb);
    int ua, ub, full, exact, e_res, e_c, e_v, e_err;
    @(negedge clk);
    opd_a = W'(a); opd_b = W'(b); do_add = ad; do_sub = sb;
    #1;
    ua = a % SPAN; ub = b % SPAN;
    if (sb) begin
      full  = ua + ((~ub) & (SPAN - 1)) + 1;
      exact = to_signed(ua) - to_signed(ub);
    end else if (ad) begin
      full  = ua + ub;
      exact = to_signed(ua) + to_signed(ub);
    end else begin
      full  = ua;
      exact = to_signed(ua);
    end
    e_res = full % SPAN;
    e_c   = (full >> W) & 1;
    e_v   = (exact < -HALF || exact > HALF - 1) ? 1 : 0;
    e_err = (ad && sb) ? 1 : 0;
    n_vec++;
    if (int'(result) != e_res || int'(carry_out) != e_c ||
        int'(ovf) != e_v || int'(ctl_err) != e_err) begin
      n_bad++;
      $display("FAIL %s a=%0h b=%0h add=%0d sub=%0d: got res=%0h c=%0d v=%0d e=%0d, want res=%0h c=%0d v=%0d e=%0d",
               tag, a, b, ad, sb, result, carry_out, ovf, ctl_err, e_res, e_c, e_v, e_err);
    end
  endtask

  task automatic check_exact(input string tag, input int a, input int b, input bit ad,
                             input bit sb, input int want_res, input int want_v);
    @(negedge clk);
    opd_a = W'(a); opd_b = W'(b); do_add = ad; do_sub = sb;
    #1;
    n_vec++;
    if (int'(result) != want_res || int'(ovf) != want_v) begin
      n_bad++;
      $display("FAIL %s got res=%0h v=%0d, want res=%0h v=%0d", tag, result, ovf, want_res, want_v);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    opd_a = '0; opd_b = '0; do_add = 1'b0; do_sub = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // reset / idle state: all zero inputs give all zero outputs (R3)
    check("R3 idle", 0, 0, 0, 0);
    // R8 worked examples
    check_exact("R8 4-6", 4'b0100, 4'b0110, 0, 1, 4'b1110, 0);
    check_exact("R8 6+-3", 4'b0110, 4'b1101, 1, 0, 4'b0011, 0);
    // R6 carry discarded
    check_exact("R6 7+-7", 4'b0111, 4'b1001, 1, 0, 4'b0000, 0);
    check("R6 carry", 4'b0111, 4'b1001, 1, 0);
    // R7 range edges
    check_exact("R7 7+1", 4'b0111, 4'b0001, 1, 0, 4'b1000, 1);
    check_exact("R7 -8-1", 4'b1000, 4'b0001, 0, 1, 4'b0111, 1);
    check_exact("R7 0--8", 4'b0000, 4'b1000, 0, 1, 4'b1000, 1);
    check_exact("R7 -8+-1", 4'b1000, 4'b1111, 1, 0, 4'b0111, 1);
    // R3 operand B has no effect in pass mode
    check_exact("R3 pass b=f", 4'b1010, 4'b1111, 0, 0, 4'b1010, 0);
    // R4 both selects behaves as subtract
    check_exact("R4 both", 4'b0100, 4'b0110, 1, 1, 4'b1110, 0);
    // exhaustive sweep: R1 add, R2 sub, R3 pass, R4 both, R5 overflow
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < SPAN; a++)
        for (int b = 0; b < SPAN; b++) begin
          case (m)
            0: check("R3 pass", a, b, 0, 0);
            1: check("R1 R5 add", a, b, 1, 0);
            2: check("R2 R5 sub", a, b, 0, 1);
            default: check("R4 both", a, b, 1, 1);
          endcase
        end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule